// File: doc/BRIEF.md
# Disk Header Identity Checker

This block watches, byte by byte, the header block at the start of a disk as it streams past. It confirms that the block begins with the header type code and a fixed 14-byte signature. It then compares the next ten bytes with an expected identity pattern held in a small register file. Any pattern entry of 0xFF is a wildcard, so a caller can match on only the fields it cares about, for example side and disk number.

A block-start strobe arms the checker. Bytes are accepted on cycles where the valid strobe is high, and idle cycles between bytes are allowed. At most one verdict is produced per block: a one-cycle done pulse together with a pass flag and an error code. The verdict comes either at the first byte that fails or after the last identity byte. The error code identifies which part of the header disagreed, and zero means success. The pattern is written through a simple address/data port and persists across blocks.

Top module: `hdr_id_check`

## Requirements
- R1: After reset, done, pass and errCode are 0, and every pattern entry holds 0xFF (wildcard), so any identity bytes are accepted.
- R2: Block byte 0 must equal 0x01. Any other value gives errCode 0x22.
- R3: Block bytes 1 to 14 must equal, in order, the bytes of parameter SIG (byte j sits at SIG[8j+7:8j]). Any mismatch gives errCode 0x21.
- R4: Block bytes 15 to 24 are compared with pattern entries 0 to 9. Entry k is written with patData when patWrEn is high and patAddr equals k. Writes to addresses 10 to 15 change no entry.
- R5: A pattern entry of 0xFF matches any byte in its position.
- R6: An identity mismatch at pattern offset k gives errCode 0x04 for k=0, 0x05 for k=1..4, 0x06 for k=5, 0x07 for k=6, 0x08 for k=7, 0x09 for k=8 and 0x10 for k=9.
- R7: Only the first mismatch in stream order sets the code. Bytes after it are ignored until the next block start.
- R8: If all 25 bytes match, done rises in the cycle after byte 24 is accepted, with pass=1 and errCode=0.
- R9: done is high for exactly one cycle per block, in the cycle after the deciding byte is accepted. pass and errCode then hold until the next block start.
- R10: blkStart clears pass and errCode and restarts at byte 0. A byte presented in the blkStart cycle is ignored. Pattern entries are kept.
- R11: Cycles with byteValid low do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blkStart | input | 1 | Start of a new header block |
| byteValid | input | 1 | byteData carries a block byte this cycle |
| byteData | input | 8 | Block byte |
| patWrEn | input | 1 | Pattern entry write enable |
| patAddr | input | 4 | Pattern entry index |
| patData | input | 8 | Pattern entry value |
| done | output | 1 | One-cycle verdict pulse |
| pass | output | 1 | Header matched |
| errCode | output | 8 | First-mismatch code, 0 if none |

## Verification
The assertions assume the block is armed by blkStart before any byte counts. They also assume blkStart is never raised in the same cycle as a byte that is meant to be checked. The stimulus always pulses blkStart alone on its own cycle, except in one deliberate test where a byte is presented in that cycle to confirm it is dropped. Streams include idle gaps between bytes. After each verdict, the remaining bytes of the block are still sent, so that the ignore rule is exercised against the registered result.

// File: rtl/hdr_id_pkg.sv
package hdr_id_pkg;

  typedef struct packed {
    logic clr;
    logic fail;
    logic succeed;
  } ctl_t;

  function automatic logic [7:0] fieldCode(input int unsigned k);
    case (k)
      0:       fieldCode = 8'h04;
      1, 2, 3, 4: fieldCode = 8'h05;
      5:       fieldCode = 8'h06;
      6:       fieldCode = 8'h07;
      7:       fieldCode = 8'h08;
      8:       fieldCode = 8'h09;
      default: fieldCode = 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/hdr_id_ctrl.sv
module hdr_id_ctrl
  import hdr_id_pkg::*;
#(
  parameter int LAST = 24,
  localparam int IDXW = $clog2(LAST + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            blkStart,
  input  logic            byteValid,
  input  logic            mismatch,
  output logic [IDXW-1:0] idx,
  output ctl_t            ctl,
  output logic            done
);

  logic active;
  logic take;

  assign take        = active && byteValid && !blkStart;
  assign ctl.clr     = blkStart;
  assign ctl.fail    = take && mismatch;
  assign ctl.succeed = take && !mismatch && (idx == IDXW'(LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.fail || ctl.succeed;
      if (blkStart) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (take) begin
        if (ctl.fail || ctl.succeed) active <= 1'b0;
        else                         idx    <= idx + 1'b1;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  blk_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkStart |=> !done);

  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IDXW'(LAST));

endmodule

// File: rtl/hdr_id_dpath.sv
module hdr_id_dpath
  import hdr_id_pkg::*;
#(
  parameter int SIG_LEN  = 14,
  parameter int ID_LEN   = 10,
  parameter logic [7:0] BLK_TYPE = 8'h01,
  parameter logic [SIG_LEN*8-1:0] SIG = '0,
  localparam int LAST = SIG_LEN + ID_LEN,
  localparam int IDXW = $clog2(LAST + 1),
  localparam int PAW  = $clog2(ID_LEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_t            ctl,
  input  logic [IDXW-1:0] idx,
  input  logic [7:0]      byteData,
  input  logic            patWrEn,
  input  logic [PAW-1:0]  patAddr,
  input  logic [7:0]      patData,
  output logic            mismatch,
  output logic            pass,
  output logic [7:0]      errCode
);

  localparam logic [7:0] WILD = 8'hFF;

  logic [7:0] patMem [ID_LEN];
  logic [7:0] code;
  logic [7:0] sigByte;
  logic [7:0] patByte;
  logic [IDXW-1:0] sigSel;
  logic [PAW-1:0]  kSel;

  for (genvar k = 0; k < ID_LEN; k++) begin : g_pat
    always_ff @(posedge clk) begin
      if (!rstN)                                      patMem[k] <= WILD;
      else if (patWrEn && patAddr == PAW'(k))         patMem[k] <= patData;
    end
  end

  assign sigSel  = idx - 1'b1;
  assign sigByte = 8'(SIG >> {sigSel, 3'b000});
  assign kSel    = PAW'(idx - IDXW'(SIG_LEN + 1));
  assign patByte = patMem[kSel];

  always_comb begin
    if (idx == '0) begin
      mismatch = (byteData != BLK_TYPE);
      code     = 8'h21 + BLK_TYPE;
    end else if (idx <= IDXW'(SIG_LEN)) begin
      mismatch = (byteData != sigByte);
      code     = 8'h21;
    end else begin
      mismatch = (patByte != WILD) && (patByte != byteData);
      code     = fieldCode(32'(kSel));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clr) begin
      errCode <= '0;
      pass    <= 1'b0;
    end else if (ctl.fail) begin
      errCode <= code;
    end else if (ctl.succeed) begin
      pass    <= 1'b1;
    end
  end

  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (errCode == 8'h00));

endmodule

// File: rtl/hdr_id_check.sv
module hdr_id_check
  import hdr_id_pkg::*;
#(
  parameter int SIG_LEN = 14,
  parameter int ID_LEN  = 10,
  parameter logic [7:0] BLK_TYPE = 8'h01,
  parameter logic [SIG_LEN*8-1:0] SIG = 112'h2A_43_56_48_2D_4F_44_4E_45_54_4E_49_4E_2A,
  localparam int PAW = $clog2(ID_LEN)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           blkStart,
  input  logic           byteValid,
  input  logic [7:0]     byteData,
  input  logic           patWrEn,
  input  logic [PAW-1:0] patAddr,
  input  logic [7:0]     patData,
  output logic           done,
  output logic           pass,
  output logic [7:0]     errCode
);

  localparam int LAST = SIG_LEN + ID_LEN;
  localparam int IDXW = $clog2(LAST + 1);

  ctl_t            ctl;
  logic [IDXW-1:0] idx;
  logic            mismatch;

  hdr_id_ctrl #(.LAST(LAST)) u_ctrl (
    .clk(clk), .rstN(rstN), .blkStart(blkStart), .byteValid(byteValid),
    .mismatch(mismatch), .idx(idx), .ctl(ctl), .done(done)
  );

  hdr_id_dpath #(
    .SIG_LEN(SIG_LEN), .ID_LEN(ID_LEN), .BLK_TYPE(BLK_TYPE), .SIG(SIG)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx), .byteData(byteData),
    .patWrEn(patWrEn), .patAddr(patAddr), .patData(patData),
    .mismatch(mismatch), .pass(pass), .errCode(errCode)
  );

  // R2
  fail_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> (errCode != 8'h00));

endmodule

// File: tb/tb_hdr_id_check.sv
module tb_hdr_id_check;

  logic       clk = 1'b0;
  logic       rstN;
  logic       blkStart, byteValid, patWrEn;
  logic [7:0] byteData, patData;
  logic [3:0] patAddr;
  logic       done, pass;
  logic [7:0] errCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdr_id_check dut (
    .clk(clk), .rstN(rstN), .blkStart(blkStart), .byteValid(byteValid),
    .byteData(byteData), .patWrEn(patWrEn), .patAddr(patAddr),
    .patData(patData), .done(done), .pass(pass), .errCode(errCode)
  );

  localparam logic [7:0] SIGB [14] = '{8'h2A, 8'h4E, 8'h49, 8'h4E, 8'h54,
    8'h45, 8'h4E, 8'h44, 8'h4F, 8'h2D, 8'h48, 8'h56, 8'h43, 8'h2A};

  // {corrupt pos A, corrupt pos B, expected code, deciding byte}; 255 = none
  localparam logic [31:0] VEC [15] = '{
    {8'd255, 8'd255, 8'h00, 8'd24},  // R8 clean
    {8'd0,   8'd255, 8'h22, 8'd0},   // R2
    {8'd5,   8'd255, 8'h21, 8'd5},   // R3
    {8'd14,  8'd255, 8'h21, 8'd14},  // R3 last signature byte
    {8'd15,  8'd255, 8'h04, 8'd15},  // R4 R6
    {8'd16,  8'd255, 8'h05, 8'd16},  // R6
    {8'd18,  8'd255, 8'h00, 8'd24},  // R5 wildcard entry 3
    {8'd19,  8'd255, 8'h05, 8'd19},  // R6
    {8'd20,  8'd255, 8'h06, 8'd20},  // R6
    {8'd21,  8'd255, 8'h07, 8'd21},  // R6
    {8'd22,  8'd255, 8'h08, 8'd22},  // R6
    {8'd23,  8'd255, 8'h09, 8'd23},  // R6
    {8'd24,  8'd255, 8'h10, 8'd24},  // R6 last identity byte
    {8'd17,  8'd20,  8'h05, 8'd17},  // R7 first wins
    {8'd18,  8'd22,  8'h08, 8'd22}   // R5 R7 wildcard then mismatch
  };

  function automatic logic [7:0] patVal(input int k);
    patVal = (k == 3) ? 8'hFF : 8'h40 + 8'(k);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runBlock(input int posA, input int posB, input logic [7:0] expCode,
                          input int dIdx, input bit fillAny, input string req);
    bit stray = 0;
    @(negedge clk); blkStart = 1'b1;
    @(negedge clk); blkStart = 1'b0;
    for (int i = 0; i < 25; i++) begin
      logic [7:0] b;
      if (i % 3 == 2) begin  // R11 idle gap
        byteValid = 1'b0;
        @(negedge clk);
        if (done) stray = 1;
      end
      if (i == 0)       b = 8'h01;
      else if (i <= 14) b = SIGB[i-1];
      else if (fillAny) b = 8'h99;
      else              b = (patVal(i-15) == 8'hFF) ? 8'hC3 : patVal(i-15);
      if (i == posA || i == posB) b = b ^ 8'h5A;
      byteValid = 1'b1; byteData = b;
      @(negedge clk);
      byteValid = 1'b0;
      if (i == dIdx) check(done == 1'b1, {req, " R9 done after deciding byte"}, done, 1);
      else if (done) stray = 1;
    end
    repeat (2) begin @(negedge clk); if (done) stray = 1; end
    check(!stray, {req, " R7 R9 no extra done"}, stray, 0);
    check(errCode == expCode, {req, " code"}, errCode, expCode);
    check(pass == (expCode == 8'h00), {req, " pass"}, pass, expCode == 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; blkStart = 0; byteValid = 0; byteData = 0;
    patWrEn = 0; patAddr = 0; patData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 0 && pass == 0 && errCode == 0, "R1 reset outputs",
          {done, pass, errCode}, 0);
    // R1 default pattern all wildcard
    runBlock(255, 255, 8'h00, 24, 1'b1, "R1 default pattern");

    // R4 load pattern
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); patWrEn = 1; patAddr = 4'(k); patData = patVal(k);
    end
    @(negedge clk); patAddr = 4'd12; patData = 8'h00;  // R4 out of range
    @(negedge clk); patWrEn = 0;

    for (int v = 0; v < 15; v++) begin
      runBlock(int'(VEC[v][31:24]), int'(VEC[v][23:16]), VEC[v][15:8],
               int'(VEC[v][7:0]), 1'b0, $sformatf("vec%0d", v));
    end

    // R10 blkStart clears a failed result
    runBlock(0, 255, 8'h22, 0, 1'b0, "R10 pre");
    @(negedge clk); blkStart = 1;
    @(negedge clk); blkStart = 0;
    check(errCode == 0 && pass == 0, "R10 cleared", errCode, 0);

    // R10 restart mid-block; byte in the blkStart cycle ignored
    for (int i = 0; i < 6; i++) begin
      byteValid = 1; byteData = (i == 0) ? 8'h01 : SIGB[i-1];
      @(negedge clk);
    end
    blkStart = 1; byteValid = 1; byteData = 8'h55;
    @(negedge clk); blkStart = 0; byteValid = 0;
    for (int i = 0; i < 25; i++) begin
      byteValid = 1;
      byteData = (i == 0) ? 8'h01 : (i <= 14) ? SIGB[i-1] :
                 (patVal(i-15) == 8'hFF ? 8'h00 : patVal(i-15));
      @(negedge clk);
      if (i == 24) check(done == 1, "R10 restart done", done, 1);
    end
    byteValid = 0;
    @(negedge clk);
    check(pass == 1 && errCode == 0, "R10 restart pass", {pass, errCode}, 9'h100);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule